// File: doc/BRIEF.md
# Register-to-Register ALU Execute Stage

This block is the execute stage of a small 32-bit load/store processor. In each cycle it takes one decoded instruction and selects two operands. The first operand is a source register value or the program counter. The second operand is a source register value or a sign-extended 16-bit immediate. The block computes one result and registers it, together with the destination register index and a write strobe, for the write-back port of the register file. Register 0 is treated like any other destination.

The operations are add, subtract, move, negate, bitwise not, and, or, arithmetic shift left and arithmetic shift right. There are also two compares, equality and signed greater-than. A compare writes a 0/1 flag into the destination register; it does not set condition codes. With the program counter as the first operand, add, subtract and move form PC-relative values. Instruction decode, memory access and branch handling belong to other stages.

Top module: `alu_exec_stage`

## Requirements
- R1: While reset is active, and until the first accepted instruction after reset, out_we is 0, out_result is 0 and out_dst is 0.
- R2: Add (op 0) gives A+B and subtract (op 1) gives A-B, both modulo 2^32. B is rs2_val when use_imm_b=0. When use_imm_b=1, B is imm16 sign-extended from bit 15.
- R3: When use_pc_a=1, operand A is pc instead of rs1_val. This applies to add, subtract and move.
- R4: Move (op 2) writes the sign-extended immediate when use_imm_b=1, and otherwise writes operand A.
- R5: Negate (op 3) writes the two's complement of A, and not (op 4) writes the bitwise inverse of A. Operand B has no effect on either.
- R6: And (op 5) and or (op 6) combine A with B bitwise, where B is a register or the sign-extended immediate.
- R7: Shift left (op 7) and shift right (op 8) move A by the low 5 bits of B. Shift left fills with zeros. Shift right copies bit 31 into the vacated bits.
- R8: Set-if-equal (op 9) writes 1 when A equals B and 0 otherwise.
- R9: Set-if-greater (op 10) writes 1 when A is greater than B as signed 32-bit numbers, and 0 otherwise.
- R10: On a clock edge where in_valid=1 and the opcode is legal, the result, dst_sel and out_we=1 appear at the outputs after that edge. After an edge with in_valid=0, out_we is 0 and out_result and out_dst keep their values.
- R11: Opcodes 11 to 15 are not legal. With in_valid=1 they leave out_we at 0 and leave out_result and out_dst unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-stage synchronizer |
| in_valid | input | 1 | An instruction is present this cycle |
| in_op | input | 4 | Operation code |
| use_pc_a | input | 1 | Operand A is pc instead of rs1_val |
| use_imm_b | input | 1 | Operand B is the sign-extended immediate instead of rs2_val |
| dst_sel | input | 4 | Destination register index |
| rs1_val | input | 32 | First source register value |
| rs2_val | input | 32 | Second source register value |
| imm16 | input | 16 | Immediate field |
| pc | input | 32 | Program counter of the instruction |
| out_result | output | 32 | Registered result |
| out_dst | output | 4 | Registered destination index |
| out_we | output | 1 | Registered write strobe |

## Verification
The assertions assume that the inputs are stable and defined for the whole cycle around each rising edge. They also assume that in_valid stays low from reset until the internal synchronized reset has released. The bench meets both assumptions. It changes inputs only on falling edges, drives every input to a defined value from time zero, and waits several cycles after releasing reset before it presents the first instruction. The PC-move and register-add properties compare against the sampled inputs of the previous cycle. For that reason the bench never changes these inputs between the edge and the check.

// File: rtl/alu_exec_pkg.sv
package alu_exec_pkg;

  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_MOV = 4'd2,
    OP_NEG = 4'd3,
    OP_NOT = 4'd4,
    OP_AND = 4'd5,
    OP_OR  = 4'd6,
    OP_SHL = 4'd7,
    OP_SHR = 4'd8,
    OP_SEQ = 4'd9,
    OP_SGT = 4'd10
  } alu_op_e;

  localparam logic [OP_W-1:0] OP_LAST = 4'd10;

endpackage

// File: rtl/alu_rst_sync.sv
module alu_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_q_n = stage_q[1];

endmodule

// File: rtl/alu_opnd_sel.sv
module alu_opnd_sel #(
  parameter int W     = 32,
  parameter int IMM_W = 16
) (
  input  logic             use_pc_a,
  input  logic             use_imm_b,
  input  logic [W-1:0]     rs1_val,
  input  logic [W-1:0]     rs2_val,
  input  logic [IMM_W-1:0] imm16,
  input  logic [W-1:0]     pc,
  output logic [W-1:0]     opnd_a,
  output logic [W-1:0]     opnd_b,
  output logic [W-1:0]     imm_ext
);

  localparam int EXT_W = W - IMM_W;

  generate
    if (EXT_W > 0) begin : g_ext
      assign imm_ext = {{EXT_W{imm16[IMM_W-1]}}, imm16};
    end else begin : g_noext
      assign imm_ext = imm16[W-1:0];
    end
  endgenerate

  always_comb begin
    opnd_a = use_pc_a  ? pc      : rs1_val;
    opnd_b = use_imm_b ? imm_ext : rs2_val;
  end

endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_exec_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [OP_W-1:0] op,
  input  logic            use_imm_b,
  input  logic [W-1:0]    opnd_a,
  input  logic [W-1:0]    opnd_b,
  input  logic [W-1:0]    imm_ext,
  output logic [W-1:0]    result,
  output logic            legal
);

  localparam int SH_W = $clog2(W);

  logic [SH_W-1:0] sh_amt;
  logic            eq_flag;
  logic            gt_flag;

  always_comb begin
    sh_amt  = opnd_b[SH_W-1:0];
    eq_flag = (opnd_a == opnd_b);
    gt_flag = ($signed(opnd_a) > $signed(opnd_b));
    legal   = (op <= OP_LAST);
    result  = '0;
    case (alu_op_e'(op))
      OP_ADD:  result = opnd_a + opnd_b;
      OP_SUB:  result = opnd_a - opnd_b;
      OP_MOV:  result = use_imm_b ? imm_ext : opnd_a;
      OP_NEG:  result = '0 - opnd_a;
      OP_NOT:  result = ~opnd_a;
      OP_AND:  result = opnd_a & opnd_b;
      OP_OR:   result = opnd_a | opnd_b;
      OP_SHL:  result = opnd_a << sh_amt;
      OP_SHR:  result = $unsigned($signed(opnd_a) >>> sh_amt);
      OP_SEQ:  result = {{(W-1){1'b0}}, eq_flag};
      OP_SGT:  result = {{(W-1){1'b0}}, gt_flag};
      default: result = '0;
    endcase
  end

endmodule

// File: rtl/alu_result_reg.sv
module alu_result_reg #(
  parameter int W    = 32,
  parameter int RA_W = 4
) (
  input  logic            clk,
  input  logic            rst_q_n,
  input  logic            load_en,
  input  logic [W-1:0]    result_d,
  input  logic [RA_W-1:0] dst_d,
  output logic [W-1:0]    result_q,
  output logic [RA_W-1:0] dst_q,
  output logic            we_q
);

  logic [W-1:0]    result_nx;
  logic [RA_W-1:0] dst_nx;
  logic            we_nx;

  always_comb begin
    we_nx     = load_en;
    result_nx = load_en ? result_d : result_q;
    dst_nx    = load_en ? dst_d    : dst_q;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      result_q <= '0;
      dst_q    <= '0;
      we_q     <= 1'b0;
    end else begin
      result_q <= result_nx;
      dst_q    <= dst_nx;
      we_q     <= we_nx;
    end
  end

endmodule

// File: rtl/alu_exec_stage.sv
module alu_exec_stage
  import alu_exec_pkg::*;
#(
  parameter int W     = 32,
  parameter int IMM_W = 16,
  parameter int NREG  = 16,
  localparam int RA_W = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [OP_W-1:0] in_op,
  input  logic            use_pc_a,
  input  logic            use_imm_b,
  input  logic [RA_W-1:0] dst_sel,
  input  logic [W-1:0]    rs1_val,
  input  logic [W-1:0]    rs2_val,
  input  logic [IMM_W-1:0] imm16,
  input  logic [W-1:0]    pc,
  output logic [W-1:0]    out_result,
  output logic [RA_W-1:0] out_dst,
  output logic            out_we
);

  logic          rst_q_n;
  logic [W-1:0]  opnd_a;
  logic [W-1:0]  opnd_b;
  logic [W-1:0]  imm_ext;
  logic [W-1:0]  alu_res;
  logic          op_legal;
  logic          load_en;

  alu_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  alu_opnd_sel #(.W(W), .IMM_W(IMM_W)) u_sel (
    .use_pc_a  (use_pc_a),
    .use_imm_b (use_imm_b),
    .rs1_val   (rs1_val),
    .rs2_val   (rs2_val),
    .imm16     (imm16),
    .pc        (pc),
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .imm_ext   (imm_ext)
  );

  alu_core #(.W(W)) u_core (
    .op        (in_op),
    .use_imm_b (use_imm_b),
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .imm_ext   (imm_ext),
    .result    (alu_res),
    .legal     (op_legal)
  );

  assign load_en = in_valid & op_legal;

  alu_result_reg #(.W(W), .RA_W(RA_W)) u_out (
    .clk      (clk),
    .rst_q_n  (rst_q_n),
    .load_en  (load_en),
    .result_d (alu_res),
    .dst_d    (dst_sel),
    .result_q (out_result),
    .dst_q    (out_dst),
    .we_q     (out_we)
  );

endmodule

// File: rtl/alu_exec_chk.sv
module alu_exec_chk #(
  parameter int W    = 32,
  parameter int RA_W = 4
) (
  input logic            clk,
  input logic            rst_q_n,
  input logic            in_valid,
  input logic [3:0]      in_op,
  input logic            use_pc_a,
  input logic            use_imm_b,
  input logic [RA_W-1:0] dst_sel,
  input logic [W-1:0]    rs1_val,
  input logic [W-1:0]    rs2_val,
  input logic [W-1:0]    pc,
  input logic [W-1:0]    out_result,
  input logic [RA_W-1:0] out_dst,
  input logic            out_we
);

  assert_we_follows_R10: assert property (@(posedge clk) disable iff (!rst_q_n)
    (in_valid && in_op <= 4'd10) |=> (out_we && out_dst == $past(dst_sel)));

  assert_idle_holds_R10: assert property (@(posedge clk) disable iff (!rst_q_n)
    !in_valid |=> (!out_we && $stable(out_result) && $stable(out_dst)));

  assert_illegal_nowrite_R11: assert property (@(posedge clk) disable iff (!rst_q_n)
    (in_valid && in_op > 4'd10) |=> (!out_we && $stable(out_result)));

  assert_flag_width_R8: assert property (@(posedge clk) disable iff (!rst_q_n)
    (in_valid && (in_op == 4'd9 || in_op == 4'd10)) |=> (out_result[W-1:1] == '0));

  assert_reg_add_R2: assert property (@(posedge clk) disable iff (!rst_q_n)
    (in_valid && in_op == 4'd0 && !use_pc_a && !use_imm_b)
      |=> (out_result == $past(rs1_val) + $past(rs2_val)));

  assert_pc_move_R3: assert property (@(posedge clk) disable iff (!rst_q_n)
    (in_valid && in_op == 4'd2 && use_pc_a && !use_imm_b) |=> (out_result == $past(pc)));

endmodule

bind alu_exec_stage alu_exec_chk #(.W(W), .RA_W(RA_W)) u_chk (
  .clk        (clk),
  .rst_q_n    (rst_q_n),
  .in_valid   (in_valid),
  .in_op      (in_op),
  .use_pc_a   (use_pc_a),
  .use_imm_b  (use_imm_b),
  .dst_sel    (dst_sel),
  .rs1_val    (rs1_val),
  .rs2_val    (rs2_val),
  .pc         (pc),
  .out_result (out_result),
  .out_dst    (out_dst),
  .out_we     (out_we)
);

// File: tb/tb_alu_exec_stage.sv
module tb_alu_exec_stage;

  typedef struct packed {
    logic [3:0]  op;
    logic        upc;
    logic        uimm;
    logic [31:0] a;
    logic [31:0] b;
    logic [15:0] imm;
    logic [31:0] pcv;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VEC [NV] = '{
    '{4'd0, 1'b0, 1'b0, 32'd5,         32'd7,         16'h0000, 32'h0,    32'd12},         // R2
    '{4'd0, 1'b0, 1'b1, 32'd100,       32'h0,         16'hFFFF, 32'h0,    32'd99},         // R2
    '{4'd0, 1'b0, 1'b0, 32'hFFFFFFFF,  32'd1,         16'h0000, 32'h0,    32'd0},          // R2
    '{4'd1, 1'b0, 1'b0, 32'd10,        32'd3,         16'h0000, 32'h0,    32'd7},          // R2
    '{4'd1, 1'b0, 1'b1, 32'd0,         32'h0,         16'h8000, 32'h0,    32'h00008000},   // R2
    '{4'd0, 1'b1, 1'b1, 32'h55,        32'h0,         16'h0010, 32'h1000, 32'h1010},       // R3
    '{4'd1, 1'b1, 1'b1, 32'h55,        32'h0,         16'h0004, 32'h1000, 32'h0FFC},       // R3
    '{4'd2, 1'b0, 1'b0, 32'hDEADBEEF,  32'h1,         16'h0000, 32'h0,    32'hDEADBEEF},   // R4
    '{4'd2, 1'b0, 1'b1, 32'h77,        32'h0,         16'h8001, 32'h0,    32'hFFFF8001},   // R4
    '{4'd2, 1'b1, 1'b0, 32'h77,        32'h9,         16'h0000, 32'h2468, 32'h2468},       // R3
    '{4'd3, 1'b0, 1'b0, 32'd1,         32'hABCD0123,  16'h0000, 32'h0,    32'hFFFFFFFF},   // R5
    '{4'd4, 1'b0, 1'b0, 32'h0F0F0F0F,  32'h12345678,  16'h0000, 32'h0,    32'hF0F0F0F0},   // R5
    '{4'd5, 1'b0, 1'b0, 32'hFF00FF00,  32'h0F0F0F0F,  16'h0000, 32'h0,    32'h0F000F00},   // R6
    '{4'd5, 1'b0, 1'b1, 32'h12345678,  32'h0,         16'h00FF, 32'h0,    32'h00000078},   // R6
    '{4'd6, 1'b0, 1'b1, 32'h10000000,  32'h0,         16'h8000, 32'h0,    32'hFFFF8000},   // R6
    '{4'd6, 1'b0, 1'b0, 32'hA0,        32'h05,        16'h0000, 32'h0,    32'hA5},         // R6
    '{4'd7, 1'b0, 1'b0, 32'd1,         32'h24,        16'h0000, 32'h0,    32'h10},         // R7
    '{4'd8, 1'b0, 1'b0, 32'h80000000,  32'd4,         16'h0000, 32'h0,    32'hF8000000},   // R7
    '{4'd8, 1'b0, 1'b0, 32'h40000000,  32'd30,        16'h0000, 32'h0,    32'd1},          // R7
    '{4'd7, 1'b0, 1'b1, 32'hFF,        32'h0,         16'h0008, 32'h0,    32'hFF00},       // R7
    '{4'd9, 1'b0, 1'b0, 32'd5,         32'd5,         16'h0000, 32'h0,    32'd1},          // R8
    '{4'd9, 1'b0, 1'b0, 32'd5,         32'd6,         16'h0000, 32'h0,    32'd0},          // R8
    '{4'd10, 1'b0, 1'b0, 32'd1,        32'hFFFFFFFF,  16'h0000, 32'h0,    32'd1},          // R9
    '{4'd10, 1'b0, 1'b0, 32'h80000000, 32'd0,         16'h0000, 32'h0,    32'd0},          // R9
    '{4'd10, 1'b0, 1'b0, 32'd9,        32'd9,         16'h0000, 32'h0,    32'd0}           // R9
  };

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [3:0]  in_op;
  logic        use_pc_a;
  logic        use_imm_b;
  logic [3:0]  dst_sel;
  logic [31:0] rs1_val;
  logic [31:0] rs2_val;
  logic [15:0] imm16;
  logic [31:0] pc;
  logic [31:0] out_result;
  logic [3:0]  out_dst;
  logic        out_we;

  int total;
  int bad;

  alu_exec_stage dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_op      (in_op),
    .use_pc_a   (use_pc_a),
    .use_imm_b  (use_imm_b),
    .dst_sel    (dst_sel),
    .rs1_val    (rs1_val),
    .rs2_val    (rs2_val),
    .imm16      (imm16),
    .pc         (pc),
    .out_result (out_result),
    .out_dst    (out_dst),
    .out_we     (out_we)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] res_exp,
                       input logic [3:0] dst_exp, input logic we_exp);
    total++;
    if (out_result !== res_exp || out_dst !== dst_exp || out_we !== we_exp) begin
      bad++;
      $display("FAIL %s: result=%h dst=%0d we=%b expected result=%h dst=%0d we=%b",
               req, out_result, out_dst, out_we, res_exp, dst_exp, we_exp);
    end
  endtask

  task automatic drive(input logic v, input logic [3:0] op, input logic upc,
                       input logic uimm, input logic [3:0] d, input logic [31:0] a,
                       input logic [31:0] b, input logic [15:0] im, input logic [31:0] p);
    in_valid  = v;
    in_op     = op;
    use_pc_a  = upc;
    use_imm_b = uimm;
    dst_sel   = d;
    rs1_val   = a;
    rs2_val   = b;
    imm16     = im;
    pc        = p;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    bad++;
    total++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    total = 0;
    bad   = 0;
    rst_n = 1'b0;
    in_valid = 1'b0; in_op = 4'd0; use_pc_a = 1'b0; use_imm_b = 1'b0;
    dst_sel = 4'd0; rs1_val = '0; rs2_val = '0; imm16 = '0; pc = '0;
    repeat (3) @(negedge clk);
    check("R1 in reset", 32'd0, 4'd0, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after release", 32'd0, 4'd0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      drive(1'b1, VEC[i].op, VEC[i].upc, VEC[i].uimm, 4'(i), VEC[i].a, VEC[i].b,
            VEC[i].imm, VEC[i].pcv);
      check($sformatf("R2-R9 vector %0d (R10 dst)", i), VEC[i].exp, 4'(i), 1'b1);
    end

    // R10: register 0 as destination, then idle cycle holds values
    drive(1'b1, 4'd0, 1'b0, 1'b0, 4'd0, 32'd40, 32'd2, 16'h0, 32'h0);
    check("R10 dst zero", 32'd42, 4'd0, 1'b1);
    drive(1'b0, 4'd1, 1'b1, 1'b1, 4'd9, 32'h1111, 32'h2222, 16'h3333, 32'h4444);
    check("R10 idle hold", 32'd42, 4'd0, 1'b0);

    // R11: illegal opcodes leave outputs unchanged
    drive(1'b1, 4'd11, 1'b0, 1'b0, 4'd5, 32'h1, 32'h2, 16'h0, 32'h0);
    check("R11 op 11", 32'd42, 4'd0, 1'b0);
    drive(1'b1, 4'd15, 1'b0, 1'b0, 4'd7, 32'h1, 32'h2, 16'h0, 32'h0);
    check("R11 op 15", 32'd42, 4'd0, 1'b0);

    // R5: operand B has no effect on negate
    drive(1'b1, 4'd3, 1'b0, 1'b1, 4'd3, 32'd2, 32'hFFFF, 16'h7FFF, 32'h0);
    check("R5 neg ignores B", 32'hFFFFFFFE, 4'd3, 1'b1);

    // R7: shift by 31 and by 32 (low 5 bits = 0)
    drive(1'b1, 4'd8, 1'b0, 1'b0, 4'd4, 32'h80000000, 32'd31, 16'h0, 32'h0);
    check("R7 shr 31", 32'hFFFFFFFF, 4'd4, 1'b1);
    drive(1'b1, 4'd7, 1'b0, 1'b0, 4'd4, 32'h3, 32'd32, 16'h0, 32'h0);
    check("R7 shl 32 wraps to 0", 32'h3, 4'd4, 1'b1);

    // R1: reset in the middle of a run clears outputs at once
    drive(1'b0, 4'd0, 1'b0, 1'b0, 4'd0, 32'h0, 32'h0, 16'h0, 32'h0);
    rst_n = 1'b0;
    #1;
    check("R1 async clear", 32'd0, 4'd0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 re-release", 32'd0, 4'd0, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule